// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Pulse Generator

This block produces a single high pulse of programmable length each time a qualified trigger arrives. The pulse length is counted in clock cycles, and no analog timing network is involved. There are two trigger pins with opposite edge sense. `trig_fall` fires on its high-to-low transition, but only while `trig_rise` is high. `trig_rise` fires on its low-to-high transition, but only while `trig_fall` is low. Tying one pin to its enabling level turns the other pin into a plain edge trigger.

An active-low clear pin, `clr_n`, overrides everything else. While it is low the output is held low and any pulse in progress stops. A build-time parameter can also make the release of the clear pin act as a third trigger. All three pins are asynchronous to the clock. Each one passes through a synchronizer, and its edges are found after synchronization.

The block is retriggerable. A qualified trigger that arrives during a pulse reloads the full width, which extends the pulse. Such a trigger is honoured only if at least `RETRIG_MIN` cycles have passed since the last accepted trigger. The width input is sampled at the moment a trigger is accepted.

Top module: `mono_oneshot`

## Requirements
- R1: After the synchronous reset `rst`, `pulse` is 0 and `pulse_n` is 1. In every cycle, `pulse_n` is the inverse of `pulse`.
- R2: A high-to-low transition on `trig_fall` starts a pulse when `trig_rise` is high. The same transition has no effect when `trig_rise` is low.
- R3: A low-to-high transition on `trig_rise` starts a pulse when `trig_fall` is low. The same transition has no effect when `trig_fall` is high.
- R4: While `clr_n` is low, `pulse` is held at 0. A pulse in progress ends with the same pin-to-output latency that a trigger uses to start one.
- R5: An accepted trigger keeps `pulse` high for exactly `width`+1 cycles, so a width of 0 gives one cycle. `width` is sampled only when the trigger is accepted, and later changes do not alter the running pulse.
- R6: A qualified trigger arriving at least `RETRIG_MIN` cycles after the last accepted trigger reloads the full width during a pulse. For an accepted retrigger S cycles after the first trigger, `pulse` stays high for S+`width`+1 cycles.
- R7: A qualified trigger arriving fewer than `RETRIG_MIN` cycles after the last accepted trigger is ignored, and the pulse ends at its original time.
- R8: A trigger edge seen while `clr_n` is low starts no pulse, because the clear wins.
- R9: With `CLR_TRIGGER`=1, a low-to-high transition on `clr_n` starts a pulse if `trig_fall` is low and `trig_rise` is high at that time. With `CLR_TRIGGER`=0, releasing `clr_n` never starts a pulse.
- R10: A trigger pin change shows on `pulse` after exactly 3 rising clock edges. These are two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_fall | input | 1 | Trigger fired by a high-to-low transition, asynchronous |
| trig_rise | input | 1 | Trigger fired by a low-to-high transition, asynchronous |
| clr_n | input | 1 | Overriding active-low clear, asynchronous |
| width | input | WIDTH_W | Pulse length minus one, in clock cycles |
| pulse | output | 1 | One-shot output, registered |
| pulse_n | output | 1 | Complement of `pulse`, registered |

## Verification
The assertions check several rules on every cycle:
- the two outputs are complementary;
- a synchronized low clear forces the output low on the next cycle and blocks any trigger acceptance;
- two accepted triggers are never closer together than `RETRIG_MIN` cycles;
- every rise of the output follows an acceptance.

The directed scenarios cover what needs a whole pulse to observe: exact pulse lengths for several widths, the fixed sampling of `width`, and the gating of each trigger pin by the other. They also cover the extended length after a well-spaced retrigger, the unchanged length after one that arrives too early, and the release-of-clear trigger in both parameter settings.

// File: rtl/mono_pkg.sv
package mono_pkg;
  typedef struct packed {
    logic fall_pin;
    logic rise_pin;
    logic clr_n;
  } pins_t;

  localparam int PIN_COUNT = 3;
  // idle levels assumed at reset: both triggers low, clear released
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/mono_sync.sv
module mono_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else if (i == 0) chain[i] <= d;
      else chain[i] <= chain[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mono_qual.sv
module mono_qual
  import mono_pkg::*;
#(
  parameter int RETRIG_MIN = 4,
  parameter bit CLR_TRIGGER = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  pins_t now,
  output logic  fire,
  output logic  clear
);
  localparam int GAP_W = $clog2(RETRIG_MIN + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(RETRIG_MIN);

  pins_t prev;
  logic [GAP_W-1:0] gap;
  logic fall_hit, rise_hit, clr_hit, gap_ok;

  always_ff @(posedge clk) begin
    if (rst) prev <= pins_t'(PIN_IDLE);
    else prev <= now;
  end

  assign fall_hit = prev.fall_pin & ~now.fall_pin & now.rise_pin;
  assign rise_hit = ~prev.rise_pin & now.rise_pin & ~now.fall_pin;

  if (CLR_TRIGGER) begin : g_clr_trig
    assign clr_hit = ~prev.clr_n & now.clr_n & ~now.fall_pin & now.rise_pin;
  end else begin : g_no_clr_trig
    assign clr_hit = 1'b0;
  end

  assign gap_ok = (gap >= GAP_LIM);
  assign clear  = ~now.clr_n;
  assign fire   = (fall_hit | rise_hit | clr_hit) & now.clr_n & gap_ok;

  // cycles since the last accepted trigger, saturating
  always_ff @(posedge clk) begin
    if (rst) gap <= GAP_LIM;
    else if (fire) gap <= GAP_W'(1);
    else if (!gap_ok) gap <= gap + 1'b1;
  end
endmodule

// File: rtl/mono_timer.sv
module mono_timer #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               fire,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse,
  output logic               pulse_n
);
  logic [WIDTH_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pulse   <= 1'b0;
      pulse_n <= 1'b1;
      remain  <= '0;
    end else if (fire) begin
      pulse   <= 1'b1;
      pulse_n <= 1'b0;
      remain  <= width;
    end else if (pulse) begin
      if (remain == '0) begin
        pulse   <= 1'b0;
        pulse_n <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mono_oneshot.sv
module mono_oneshot
  import mono_pkg::*;
#(
  parameter int WIDTH_W = 16,
  parameter int RETRIG_MIN = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit CLR_TRIGGER = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_fall,
  input  logic               trig_rise,
  input  logic               clr_n,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse,
  output logic               pulse_n
);
  logic [PIN_COUNT-1:0] pins_raw, pins_sync;
  logic fire_s, clear_s;

  assign pins_raw = {trig_fall, trig_rise, clr_n};

  mono_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_sync)
  );

  mono_qual #(.RETRIG_MIN(RETRIG_MIN), .CLR_TRIGGER(CLR_TRIGGER)) u_qual (
    .clk(clk), .rst(rst), .now(pins_t'(pins_sync)), .fire(fire_s), .clear(clear_s)
  );

  mono_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk(clk), .rst(rst), .clear(clear_s), .fire(fire_s), .width(width),
    .pulse(pulse), .pulse_n(pulse_n)
  );
endmodule

// File: rtl/mono_oneshot_chk.sv
module mono_oneshot_chk #(
  parameter int RETRIG_MIN = 4
) (
  input logic clk,
  input logic rst,
  input logic pulse,
  input logic pulse_n,
  input logic clear,
  input logic fire
);
  int unsigned since;

  always_ff @(posedge clk) begin
    if (rst) since <= RETRIG_MIN;
    else if (fire) since <= 1;
    else if (since < RETRIG_MIN) since <= since + 1;
  end

  a_r1_complement: assert property (@(posedge clk) disable iff (rst)
    pulse_n == ~pulse);

  a_r4_clear_low: assert property (@(posedge clk) disable iff (rst)
    clear |=> !pulse);

  a_r8_clear_blocks: assert property (@(posedge clk) disable iff (rst)
    clear |-> !fire);

  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    fire |-> since >= RETRIG_MIN);

  a_r5_start: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse);

  a_r10_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(fire));
endmodule

bind mono_oneshot mono_oneshot_chk #(.RETRIG_MIN(RETRIG_MIN)) u_chk (
  .clk(clk), .rst(rst), .pulse(pulse), .pulse_n(pulse_n),
  .clear(clear_s), .fire(fire_s)
);

// File: tb/test_mono_oneshot.sv
module test_mono_oneshot;
  localparam int PERIOD = 10;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fa = 1'b0, rb = 1'b0, cn = 1'b1;
  logic [WW-1:0] w = '0;
  logic p0, pn0, p1, pn1;
  int cnt0 = 0, cnt1 = 0, checks = 0, fails = 0;
  bit comp_bad = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mono_oneshot #(.WIDTH_W(WW), .RETRIG_MIN(4), .CLR_TRIGGER(1'b1)) i_mono_oneshot (
    .clk(clk), .rst(rst), .trig_fall(fa), .trig_rise(rb), .clr_n(cn),
    .width(w), .pulse(p0), .pulse_n(pn0));

  mono_oneshot #(.WIDTH_W(WW), .RETRIG_MIN(4), .CLR_TRIGGER(1'b0)) i_mono_oneshot_noclr (
    .clk(clk), .rst(rst), .trig_fall(fa), .trig_rise(rb), .clr_n(cn),
    .width(w), .pulse(p1), .pulse_n(pn1));

  always @(negedge clk) begin
    if (!rst) begin
      if (p0) cnt0++;
      if (p1) cnt1++;
      if (pn0 !== ~p0 || pn1 !== ~p1) comp_bad = 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    cnt0 = 0;
    cnt1 = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset pulse", int'(p0), 0);
    chk("R1 reset pulse_n", int'(pn0), 1);
  endtask

  task automatic t_fall();
    w = 7; fa = 1'b1; cyc(2); rb = 1'b1; cyc(6);
    clr_counts(); fa = 1'b0; cyc(20);
    chk("R2 fall with rise_pin high", cnt0, 8);
    rb = 1'b0; cyc(6); fa = 1'b1; cyc(6);
    clr_counts(); fa = 1'b0; cyc(20);
    chk("R2 fall with rise_pin low", cnt0, 0);
  endtask

  task automatic t_rise_latency();
    w = 5; clr_counts(); rb = 1'b1;
    cyc(2); chk("R10 no output after 2 edges", int'(p0), 0);
    cyc(1); chk("R10 output after 3 edges", int'(p0), 1);
    cyc(20); chk("R3 rise with fall_pin low", cnt0, 6);
    rb = 1'b0; cyc(6); fa = 1'b1; cyc(6);
    clr_counts(); rb = 1'b1; cyc(20);
    chk("R3 rise with fall_pin high", cnt0, 0);
    rb = 1'b0; cyc(3); fa = 1'b0; cyc(6);
  endtask

  task automatic t_width();
    w = 0; clr_counts(); rb = 1'b1; cyc(10);
    chk("R5 width zero gives one cycle", cnt0, 1);
    rb = 1'b0; cyc(8);
    w = 8; clr_counts(); rb = 1'b1; cyc(5); w = 30; cyc(30);
    chk("R5 width sampled at accept", cnt0, 9);
    rb = 1'b0; w = 10; cyc(8);
  endtask

  task automatic t_retrig(input int s, input int exp, input string req);
    clr_counts(); rb = 1'b1; cyc(1); rb = 1'b0; cyc(s - 1); rb = 1'b1;
    cyc(40);
    chk(req, cnt0, exp);
    rb = 1'b0; cyc(8);
  endtask

  task automatic t_clear();
    w = 20; clr_counts(); rb = 1'b1; cyc(5);
    cn = 1'b0; cyc(2); rb = 1'b0; cyc(2); rb = 1'b1; cyc(20);
    chk("R4 clear ends pulse", cnt0, 5);
    chk("R8 trigger during clear ignored", cnt0, 5);
    clr_counts(); cn = 1'b1; cyc(30);
    chk("R9 clear release triggers when enabled", cnt0, 21);
    chk("R9 clear release silent when disabled", cnt1, 0);
    rb = 1'b0; cyc(6);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(4);
    t_reset();
    t_fall();
    t_rise_latency();
    t_width();
    w = 10;
    t_retrig(6, 17, "R6 spaced retrigger extends");
    t_retrig(2, 11, "R7 early retrigger ignored");
    t_clear();
    chk("R1 complement every cycle", int'(comp_bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule